// File: doc/BRIEF.md
# Rewindable Synchronous FIFO

A single-clock FIFO whose consumer may step its read position backward by a small number of entries. Data that has been popped stays in storage until the consumer commits it. Until then, the consumer can restore and re-read up to a small number of entries per rewind request.

The physical store has 16 entries. Occupancy is measured from a commit pointer rather than from the read pointer, and the full flag fires at 14 entries. Data between the commit pointer and the write pointer can therefore never be overwritten, and rewinding cannot expose corrupted data.

The read data output always shows the entry at the read pointer. A pop advances past that entry.

Top module: `rewind_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0 and `rew_err` is 0.
- R2: Entries leave in push order; `dout` shows the oldest entry not yet popped, and a pop advances it to the next one.
- R3: `full` is 1 exactly when 14 entries are held between the commit pointer and the write pointer (13 held gives 0). A push while `full` is ignored: nothing is stored and the write pointer does not move.
- R4: A pop while `empty` (read pointer equal to write pointer) is ignored and leaves the read pointer unchanged.
- R5: A push and a pop in the same cycle both take effect.
- R6: An accepted rewind of N entries (N = 1 or 2) moves the read pointer back by N. `dout` again shows the entry popped N pops earlier, and `empty` clears.
- R7: A rewind with N = 0, with N greater than 2, or with N greater than the number of popped but uncommitted entries is rejected. The read pointer does not move, and `rew_err` is 1 for the single cycle that follows the request.
- R8: When a rewind request and a pop arrive in the same cycle, the pop is discarded, whether or not the rewind is accepted.
- R9: `commit` moves the commit pointer to the read pointer value that results from that cycle. This releases occupancy, so `full` drops once fewer than 14 entries remain held.
- R10: Entries between the commit pointer and the write pointer are never overwritten. Values re-read after a rewind equal the values originally pushed, even when the FIFO was full in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push | input | 1 | Write `din` at the tail |
| din | input | DATA_W | Write data |
| pop | input | 1 | Advance past the entry shown on `dout` |
| dout | output | DATA_W | Entry at the read pointer |
| rew | input | 1 | Rewind request |
| rew_n | input | STEP_W | Number of entries to rewind |
| commit | input | 1 | Release entries behind the read pointer |
| full | output | 1 | 14 entries held since the commit point |
| empty | output | 1 | Nothing left to pop |
| rew_err | output | 1 | Previous cycle's rewind request was rejected |

## Verification
The bench uses the default parameters: 8-bit data, 16 physical entries and a guard of two. With these values, full occupancy is reached in 14 pushes, and a three-entry rewind request lies just beyond the legal limit. The bench also reaches the state in which the FIFO is full and empty at once, with everything popped and nothing committed. From that state it rewinds, re-reads the data, and confirms that the pushes attempted while full left nothing behind.

// File: rtl/rewind_fifo.sv
module rewind_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int GUARD  = 2,
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  input  logic              rew,
  input  logic [STEP_W-1:0] rew_n,
  input  logic              commit,
  output logic              full,
  output logic              empty,
  output logic              rew_err
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CAP   = DEPTH - GUARD;
  localparam int PW    = ADDR_W + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q, cm_q, rd_nxt;

  wire [PW-1:0] held     = wr_q - cm_q;
  wire [PW-1:0] unclaim  = rd_q - cm_q;
  wire [PW-1:0] step_ext = {{(PW-STEP_W){1'b0}}, rew_n};

  assign full  = (held == PW'(CAP));
  assign empty = (rd_q == wr_q);
  assign dout  = mem[rd_q[ADDR_W-1:0]];

  wire push_ok = push & ~full;
  wire pop_ok  = pop & ~empty & ~rew;
  wire rew_ok  = rew && (rew_n != '0) && (int'(rew_n) <= GUARD) && (step_ext <= unclaim);

  always_comb begin
    if (rew_ok)      rd_nxt = rd_q - step_ext;
    else if (pop_ok) rd_nxt = rd_q + PW'(1);
    else             rd_nxt = rd_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      cm_q    <= '0;
      rew_err <= 1'b0;
    end else begin
      wr_q    <= wr_q + {{(PW-1){1'b0}}, push_ok};
      rd_q    <= rd_nxt;
      if (commit) cm_q <= rd_nxt;
      rew_err <= rew & ~rew_ok;
    end
  end

  always_ff @(posedge clk)
    if (push_ok) mem[wr_q[ADDR_W-1:0]] <= din;

  a_r3_full_blocks_push: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push) |=> (wr_q == $past(wr_q)));
  a_r4_empty_blocks_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !rew) |=> (rd_q == $past(rd_q)));
  a_r10_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    held <= PW'(CAP));
  a_r2_rd_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    unclaim <= held);
  a_r7_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    rew_err |-> (rd_q == $past(rd_q)));
endmodule

// File: tb/tb_rewind_fifo.sv
module tb_rewind_fifo;
  logic clk = 0, rst_n = 0;
  logic push = 0, pop = 0, rew = 0, commit = 0;
  logic [7:0] din = 0;
  logic [1:0] rew_n = 0;
  logic [7:0] dout;
  logic full, empty, rew_err;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  rewind_fifo dut (.clk(clk), .rst_n(rst_n), .push(push), .din(din), .pop(pop),
    .dout(dout), .rew(rew), .rew_n(rew_n), .commit(commit),
    .full(full), .empty(empty), .rew_err(rew_err));

  always #10 clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic ps, input logic [7:0] d, input logic pp,
                     input logic rw, input logic [1:0] st, input logic cm);
    push = ps; din = d; pop = pp; rew = rw; rew_n = st; commit = cm;
    @(posedge clk); #5;
    push = 0; pop = 0; rew = 0; rew_n = 0; commit = 0;
  endtask

  task automatic t_reset();
    chk("R1 empty", empty, 1); chk("R1 full", full, 0); chk("R1 err", rew_err, 0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 3; i++) cyc(1, 8'h10 + 8'(i), 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      chk("R2 order", dout, 8'h10 + i);
      cyc(0, 0, 1, 0, 0, 0);
    end
    chk("R2 drained", empty, 1);
    cyc(0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_pop_empty();
    cyc(0, 0, 1, 0, 0, 0);
    chk("R4 still empty", empty, 1);
    cyc(1, 8'h2A, 0, 0, 0, 0);
    chk("R4 not empty", empty, 0);
    chk("R4 dout", dout, 8'h2A);
    cyc(0, 0, 1, 0, 0, 1);
    chk("R4 drained", empty, 1);
  endtask

  task automatic t_simul();
    cyc(1, 8'h30, 0, 0, 0, 0);
    cyc(1, 8'h31, 1, 0, 0, 0);
    chk("R5 pop took effect", dout, 8'h31);
    chk("R5 push took effect", empty, 0);
    cyc(0, 0, 1, 0, 0, 1);
    chk("R5 drained", empty, 1);
  endtask

  task automatic t_full_rewind();
    for (int i = 0; i < 13; i++) cyc(1, 8'h40 + 8'(i), 0, 0, 0, 0);
    chk("R3 13 held", full, 0);
    cyc(1, 8'h4D, 0, 0, 0, 0);
    chk("R3 14 held", full, 1);
    cyc(1, 8'hEE, 0, 0, 0, 0);
    for (int i = 0; i < 14; i++) begin
      chk("R2 full order", dout, 8'h40 + i);
      cyc(0, 0, 1, 0, 0, 0);
    end
    chk("R3 empty after drain", empty, 1);
    chk("R3 full while uncommitted", full, 1);
    cyc(1, 8'hEF, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 2'd2, 0);
    chk("R6 rewind 2 dout", dout, 8'h4C);
    chk("R6 empty cleared", empty, 0);
    chk("R6 no err", rew_err, 0);
    cyc(0, 0, 0, 1, 2'd3, 0);
    chk("R7 step 3 err", rew_err, 1);
    chk("R7 step 3 dout", dout, 8'h4C);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R7 err one cycle", rew_err, 0);
    cyc(0, 0, 0, 1, 2'd1, 0);
    chk("R10 rewind 1 dout", dout, 8'h4B);
    cyc(0, 0, 1, 0, 0, 1);
    chk("R9 full released", full, 0);
    cyc(0, 0, 0, 1, 2'd1, 0);
    chk("R7 beyond commit err", rew_err, 1);
    chk("R7 beyond commit dout", dout, 8'h4C);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R10 last", dout, 8'h4D);
    cyc(0, 0, 1, 0, 0, 1);
    chk("R3 ignored pushes absent", empty, 1);
  endtask

  task automatic t_rew_vs_pop();
    cyc(1, 8'h50, 0, 0, 0, 0);
    cyc(1, 8'h51, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0);
    cyc(0, 0, 1, 1, 2'd1, 0);
    chk("R8 rewind wins", dout, 8'h51);
    chk("R8 not empty", empty, 0);
    cyc(0, 0, 1, 1, 2'd0, 0);
    chk("R7 step 0 err", rew_err, 1);
    chk("R8 pop dropped on reject", dout, 8'h51);
    cyc(0, 0, 1, 0, 0, 1);
    chk("R9 drained", empty, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    t_reset();
    t_order();
    t_pop_empty();
    t_simul();
    t_full_rewind();
    t_rew_vs_pop();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule